// File: doc/BRIEF.md
# Serial Port Handshake Control and Diagnostic Loopback

This block sits beside a 16550-style serial port and owns its handshake control register. A CPU writes a 5-bit control value over a small register bus. Each bit has one job: assert the active-low data-terminal-ready pin, assert the active-low request-to-send pin, provide a spare loopback ring-indicator value, enable the interrupt output, or select diagnostic loopback. The block drives the modem output pins, the serial output line and the gated interrupt line. It also decides where the serial input and the four modem status signals come from: the external pins, or an internal loopback path.

In loopback mode the serial output is parked high and the modem outputs are forced inactive. The receiver is fed from the transmit shift register. The four internal status signals are taken from the low four control bits instead of the pins. This lets software exercise the whole port without touching the line. The block also keeps two receive status flags, data-ready and overrun. It updates them from strobes sent by the receiver, and software can read them on a second bus address.

Top module: `uart_hs_ctrl`

## Requirements
- R1: After a synchronous reset, the control register reads 0, both status flags read 0, `dtrN` and `rtsN` are 1 and loopback is off.
- R2: A write to address 0 stores `wrData[4:0]` in the control register. Reading address 0 returns the stored value in bits 4:0, and bits 7:5 always read 0. A written value acts on the outputs from the cycle after the write edge.
- R3: Outside loopback, `dtrN` is the inverse of control bit 0 and `rtsN` is the inverse of control bit 1.
- R4: `irqOut` equals `irqReq` AND control bit 3, in both modes.
- R5: Outside loopback, `serOut` follows `txShiftOut` and `rxSerIn` follows `serIn`. `modemStat` is the inverse of the active-low pins, with bit 0 DSR from `dsrN`, bit 1 CTS from `ctsN`, bit 2 RI from `riN` and bit 3 DCD from `dcdN`.
- R6: When control bit 4 is 1 (loopback), `serOut` is 1, `rxSerIn` follows `txShiftOut`, and `dtrN` and `rtsN` are both 1, whatever bits 0 and 1 hold.
- R7: In loopback, `modemStat` bit k equals control bit k for k = 0..3, and the external modem pins have no effect on it.
- R8: Outside loopback, control bit 2 has no effect on any output. It is only stored and read back.
- R9: Status bit 0 (data-ready, at address 1) is set by an `rxCharIn` pulse and cleared by an `rxDrained` pulse. If both come in the same cycle, it is set.
- R10: Status bit 1 (overrun, at address 1) is set by an `rxCharIn` pulse while data-ready is already 1. A read (`rdEn`) at address 1 clears it, unless a new overrun occurs in that same cycle, in which case it stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (side effect on status) |
| addr | input | 2 | Register address: 0 control, 1 status |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for the addressed register |
| rxCharIn | input | 1 | Receiver strobe: a character arrived |
| rxDrained | input | 1 | Receiver strobe: no received data remains |
| txShiftOut | input | 1 | Transmit shift register serial output |
| serIn | input | 1 | External serial input pin |
| serOut | output | 1 | External serial output pin |
| rxSerIn | output | 1 | Serial data to the receiver |
| dsrN | input | 1 | External DSR, active low |
| ctsN | input | 1 | External CTS, active low |
| riN | input | 1 | External RI, active low |
| dcdN | input | 1 | External DCD, active low |
| modemStat | output | 4 | Internal active-high status {DCD, RI, CTS, DSR} |
| dtrN | output | 1 | DTR pin, active low |
| rtsN | output | 1 | RTS pin, active low |
| irqReq | input | 1 | Interrupt request from port logic |
| irqOut | output | 1 | Gated interrupt output |

## Verification
The bench uses the default 8-bit data bus and 2-bit address. With these values the control register has only 32 values, and there are 128 combinations of the seven routed inputs. The sweep therefore covers every control value against every pin, serial and interrupt pattern in both modes. Each of those values is also written with junk in bits 7:5, which checks that the upper bits read back as zero. Directed sequences then cover the status flags: a strobe collision, a read that clashes with a new overrun, and a set-and-drain in the same cycle.

// File: rtl/uart_hs_pkg.sv
package uart_hs_pkg;
  localparam int CTRL_W = 5;
  localparam int MODEM_W = 4;

  typedef struct packed {
    logic loopEn;
    logic irqEn;
    logic riLoop;
    logic rtsOn;
    logic dtrOn;
  } hsCtrl_t;
endpackage

// File: rtl/uart_hs_regs.sv
module uart_hs_regs
  import uart_hs_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2,
  parameter int CTRL_ADDR = 0,
  parameter int STAT_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              rxCharIn,
  input  logic              rxDrained,
  output hsCtrl_t           ctrl
);
  localparam int PAD_W = DATA_W - CTRL_W;

  logic [CTRL_W-1:0] ctrlReg;
  logic dataReady;
  logic overrun;
  logic ctrlHit;
  logic statRead;
  logic ovrEvent;

  assign ctrlHit  = wrEn && (addr == ADDR_W'(CTRL_ADDR));
  assign statRead = rdEn && (addr == ADDR_W'(STAT_ADDR));
  assign ovrEvent = rxCharIn && dataReady;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrlReg <= '0;
    end else if (ctrlHit) begin
      ctrlReg <= wrData[CTRL_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dataReady <= 1'b0;
    end else if (rxCharIn) begin
      dataReady <= 1'b1;
    end else if (rxDrained) begin
      dataReady <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      overrun <= 1'b0;
    end else if (ovrEvent) begin
      overrun <= 1'b1;
    end else if (statRead) begin
      overrun <= 1'b0;
    end
  end

  assign ctrl = hsCtrl_t'(ctrlReg);

  always_comb begin
    rdData = '0;
    if (addr == ADDR_W'(CTRL_ADDR)) begin
      rdData = {{PAD_W{1'b0}}, ctrlReg};
    end else if (addr == ADDR_W'(STAT_ADDR)) begin
      rdData = {{(DATA_W-2){1'b0}}, overrun, dataReady};
    end
  end

  // R2: a control write is visible in the register after the edge
  assert_ctrl_write_R2: assert property (@(posedge clk) disable iff (rst)
    ctrlHit |=> (ctrlReg == $past(wrData[CTRL_W-1:0])));

  // R9: an arrival strobe always leaves data-ready set
  assert_ready_set_R9: assert property (@(posedge clk) disable iff (rst)
    rxCharIn |=> dataReady);

  // R9: drain without arrival clears data-ready
  assert_ready_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (rxDrained && !rxCharIn) |=> !dataReady);

  // R10: arrival on top of unread data flags overrun
  assert_overrun_set_R10: assert property (@(posedge clk) disable iff (rst)
    (rxCharIn && dataReady) |=> overrun);

  // R10: a status read without a clashing overrun clears it
  assert_overrun_clear_R10: assert property (@(posedge clk) disable iff (rst)
    (statRead && !(rxCharIn && dataReady)) |=> !overrun);
endmodule

// File: rtl/uart_hs_route.sv
module uart_hs_route
  import uart_hs_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  hsCtrl_t            ctrl,
  input  logic               txShiftOut,
  input  logic               serIn,
  output logic               serOut,
  output logic               rxSerIn,
  input  logic [MODEM_W-1:0] modemPinN,
  output logic [MODEM_W-1:0] modemStat,
  output logic               dtrN,
  output logic               rtsN,
  input  logic               irqReq,
  output logic               irqOut
);
  logic [MODEM_W-1:0] loopVec;

  assign loopVec = {ctrl.irqEn, ctrl.riLoop, ctrl.rtsOn, ctrl.dtrOn};

  genvar k;
  generate
    for (k = 0; k < MODEM_W; k++) begin : g_stat
      assign modemStat[k] = ctrl.loopEn ? loopVec[k] : ~modemPinN[k];
    end
  endgenerate

  assign serOut  = ctrl.loopEn ? 1'b1 : txShiftOut;
  assign rxSerIn = ctrl.loopEn ? txShiftOut : serIn;
  assign dtrN    = ctrl.loopEn | ~ctrl.dtrOn;
  assign rtsN    = ctrl.loopEn | ~ctrl.rtsOn;
  assign irqOut  = irqReq & ctrl.irqEn;

  // R6: loopback parks the line and the modem outputs
  assert_loop_idle_R6: assert property (@(posedge clk) disable iff (rst)
    ctrl.loopEn |-> (serOut && dtrN && rtsN && (rxSerIn == txShiftOut)));

  // R4: no interrupt leaves the block while disabled
  assert_irq_gate_R4: assert property (@(posedge clk) disable iff (rst)
    !ctrl.irqEn |-> !irqOut);

  // R5: normal mode passes the line straight through
  assert_line_pass_R5: assert property (@(posedge clk) disable iff (rst)
    !ctrl.loopEn |-> ((serOut == txShiftOut) && (rxSerIn == serIn)));
endmodule

// File: rtl/uart_hs_ctrl.sv
module uart_hs_ctrl
  import uart_hs_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              rxCharIn,
  input  logic              rxDrained,
  input  logic              txShiftOut,
  input  logic              serIn,
  output logic              serOut,
  output logic              rxSerIn,
  input  logic              dsrN,
  input  logic              ctsN,
  input  logic              riN,
  input  logic              dcdN,
  output logic [3:0]        modemStat,
  output logic              dtrN,
  output logic              rtsN,
  input  logic              irqReq,
  output logic              irqOut
);
  hsCtrl_t ctrl;
  logic [MODEM_W-1:0] modemPinN;

  assign modemPinN = {dcdN, riN, ctsN, dsrN};

  uart_hs_regs #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W),
    .CTRL_ADDR(0),
    .STAT_ADDR(1)
  ) i_regs (
    .clk(clk),
    .rst(rst),
    .wrEn(wrEn),
    .rdEn(rdEn),
    .addr(addr),
    .wrData(wrData),
    .rdData(rdData),
    .rxCharIn(rxCharIn),
    .rxDrained(rxDrained),
    .ctrl(ctrl)
  );

  uart_hs_route i_route (
    .clk(clk),
    .rst(rst),
    .ctrl(ctrl),
    .txShiftOut(txShiftOut),
    .serIn(serIn),
    .serOut(serOut),
    .rxSerIn(rxSerIn),
    .modemPinN(modemPinN),
    .modemStat(modemStat),
    .dtrN(dtrN),
    .rtsN(rtsN),
    .irqReq(irqReq),
    .irqOut(irqOut)
  );
endmodule

// File: tb/test_uart_hs_ctrl.sv
`timescale 1ns/1ps
module test_uart_hs_ctrl;
  localparam real PERIOD = 20.0;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic rxCharIn = 1'b0, rxDrained = 1'b0;
  logic txShiftOut = 1'b0, serIn = 1'b0;
  logic serOut, rxSerIn;
  logic dsrN = 1'b1, ctsN = 1'b1, riN = 1'b1, dcdN = 1'b1;
  logic [3:0] modemStat;
  logic dtrN, rtsN;
  logic irqReq = 1'b0;
  logic irqOut;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(PERIOD/2) clk = ~clk;

  uart_hs_ctrl i_uart_hs_ctrl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .rxCharIn(rxCharIn),
    .rxDrained(rxDrained), .txShiftOut(txShiftOut), .serIn(serIn),
    .serOut(serOut), .rxSerIn(rxSerIn), .dsrN(dsrN), .ctsN(ctsN),
    .riN(riN), .dcdN(dcdN), .modemStat(modemStat), .dtrN(dtrN),
    .rtsN(rtsN), .irqReq(irqReq), .irqOut(irqOut)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wrCtrl(input logic [7:0] v);
    @(negedge clk);
    wrEn = 1'b1; addr = 2'd0; wrData = v;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic pulse(input logic ci, input logic dr, input logic rd);
    @(negedge clk);
    rxCharIn = ci; rxDrained = dr; rdEn = rd; addr = 2'd1;
    @(negedge clk);
    rxCharIn = 1'b0; rxDrained = 1'b0; rdEn = 1'b0;
  endtask

  task automatic readStat(input string req, input logic [1:0] exp);
    addr = 2'd1;
    #1;
    chk(req, {30'd0, rdData[1:0]}, {30'd0, exp});
    chk(req, {24'd0, rdData[7:2], 2'b00}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R1: reset state
    addr = 2'd0; #1;
    chk("R1 ctrl", {24'd0, rdData}, 32'd0);
    chk("R1 pins", {30'd0, dtrN, rtsN}, 32'd3);
    chk("R1 loop off", {31'd0, serOut}, {31'd0, txShiftOut});
    readStat("R1 status", 2'b00);

    // R2 R3 R4 R5 R6 R7 R8: full sweep
    for (int c = 0; c < 32; c++) begin
      wrCtrl(8'(c) | 8'he0);
      addr = 2'd0; #1;
      chk("R2 readback", {24'd0, rdData}, c);
      for (int v = 0; v < 128; v++) begin
        logic [6:0] p;
        logic lp;
        logic [8:0] act, exp;
        p = 7'(v);
        {irqReq, serIn, txShiftOut, dcdN, riN, ctsN, dsrN} = p;
        #1;
        lp = c[4];
        exp[0] = lp ? 1'b1 : ~c[0];
        exp[1] = lp ? 1'b1 : ~c[1];
        exp[2] = lp ? 1'b1 : p[4];
        exp[3] = lp ? p[4] : p[5];
        exp[4] = p[6] & c[3];
        exp[8:5] = lp ? 4'(c) : ~p[3:0];
        act = {modemStat, irqOut, rxSerIn, serOut, rtsN, dtrN};
        if (lp) chk("R4 R6 R7 loopback routing", {23'd0, act}, {23'd0, exp});
        else    chk("R3 R4 R5 R8 normal routing", {23'd0, act}, {23'd0, exp});
      end
    end
    wrCtrl(8'h00);
    irqReq = 1'b0;

    // R9 R10: status flags
    pulse(1, 0, 0); readStat("R9 set", 2'b01);
    pulse(1, 0, 0); readStat("R10 set", 2'b11);
    pulse(0, 0, 1); readStat("R10 read clears", 2'b01);
    pulse(0, 1, 0); readStat("R9 drain clears", 2'b00);
    pulse(1, 1, 0); readStat("R9 set wins", 2'b01);
    pulse(1, 0, 1); readStat("R10 set beats read", 2'b11);
    pulse(0, 1, 1); readStat("R9 R10 drain and read", 2'b00);
    pulse(1, 1, 0); readStat("R9 set over drain", 2'b01);
    pulse(1, 1, 0); readStat("R10 arrival while ready", 2'b11);
    pulse(0, 0, 0); readStat("R10 holds without read", 2'b11);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule